// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of which reset sources have hit the chip since software last looked. There are five causes: power-on, the external reset pin, the watchdog, brown-out detection and a software-requested system reset. Each cause owns one sticky status bit. A status bit stays set until software writes a one to that bit position. The four non-power-on sources arrive as asynchronous levels or pulses. Each one passes through a two-flop synchronizer before it can set its bit.

Power-on reset is the block's own asynchronous reset (`rst_ni`). While it is active, the register is loaded with its default value: the power-on and external-pin bits are set and the other bits are clear. If a source input is still high after power-on reset is released, it flows through the synchronizer and sets its bit, so a reset that outlasts power-on reset is still recorded. The other reset sources never clear the register. Only power-on reset reloads the defaults.

The bus side is a plain write strobe with a 32-bit data word. The read port shows the register continuously, zero-extended to the bus width.

Top module: `rstc_status`

## Requirements
- R1: Status bit positions are: bit 0 power-on, bit 1 external pin, bit 2 watchdog, bit 3 brown-out, bit 4 software system reset. Source input `src_i` bit k drives status bit k+1 (k=0 external, 1 watchdog, 2 brown-out, 3 software).
- R2: While `rst_ni` is low and after it rises, `rd_data_o` reads 32'h0000_0003 until some other event changes it.
- R3: A source held high across the release of `rst_ni` sets its bit on top of the default value.
- R4: With `wr_en_i` high, a 1 in `wr_data_i` bit n (n<5) clears status bit n at that clock edge.
- R5: With `wr_en_i` high, a 0 in `wr_data_i` bit n leaves status bit n unchanged.
- R6: `rd_data_o` bits 31:5 always read zero, and writes to those bits have no effect.
- R7: If a synchronized cause is active in the same cycle as a clearing write to its bit, the bit stays set.
- R8: A source that goes high and is sampled at one rising edge shows in `rd_data_o` after the third rising edge (two synchronizer flops plus the status flop). A one-cycle pulse is enough.
- R9: Bit 0 is set only by power-on reset. Non-power-on causes never clear any bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| src_i | input | 4 | Asynchronous reset-source levels: external, watchdog, brown-out, software |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data, a one clears the matching status bit |
| rd_data_o | output | 32 | Status register, zero-extended |

## Verification
Two events can fall in the same cycle: a synchronized cause setting a bit, and a software write clearing that same bit. The bench provokes this by holding the brown-out input high across power-on release. It then writes a one to the brown-out bit while the synchronized level is still active, and checks that the bit reads back set. A second case writes a clear to one bit in the same cycle that a pulse on a different source enters the synchronizer. The read-back must show the old bit cleared and the new bit set.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned CAUSE_W = 5;
  localparam int unsigned SRC_W   = CAUSE_W - 1;

  typedef enum int unsigned {
    CAUSE_POR  = 0,
    CAUSE_EXT  = 1,
    CAUSE_WDT  = 2,
    CAUSE_BOD  = 3,
    CAUSE_SOFT = 4
  } cause_e;

  localparam logic [CAUSE_W-1:0] POR_DEFAULT =
    CAUSE_W'((1 << CAUSE_POR) | (1 << CAUSE_EXT));
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_bits.sv
module rstc_bits #(
  parameter int unsigned         WIDTH   = 5,
  parameter logic [WIDTH-1:0]    DEFAULT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic clr;
    assign clr = wr_en_i & wr_data_i[i];

    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= DEFAULT[i];
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr)      q_o[i] <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    // R4
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[i] && !set_i[i]) |=> !q_o[i]);
    // R5
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !(wr_en_i && wr_data_i[i])) |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DATA_W - CAUSE_W;

  logic [SRC_W-1:0]   src_sync;
  logic [CAUSE_W-1:0] set_vec;
  logic [CAUSE_W-1:0] status_q;

  rstc_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .q_o    (src_sync)
  );

  // power-on bit has no runtime source
  assign set_vec = {src_sync, 1'b0};

  rstc_bits #(.WIDTH(CAUSE_W), .DEFAULT(POR_DEFAULT)) u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i[CAUSE_W-1:0]),
    .q_o       (status_q)
  );

  assign rd_data_o = {{PAD_W{1'b0}}, status_q};

  // R9
  por_bit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(rd_data_o[CAUSE_POR]));
  // R8
  src_to_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sync[CAUSE_WDT-1] |=> rd_data_o[CAUSE_WDT]);
endmodule

// File: tb/sim_rstc_status.sv
module sim_rstc_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rstc_status u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
  );

  // {src[3:0], clear mask[4:0], expected status[4:0]}
  localparam logic [13:0] VEC [10] = '{
    {4'b0000, 5'b00001, 5'b00010},
    {4'b0010, 5'b00000, 5'b00110},
    {4'b0000, 5'b00110, 5'b00000},
    {4'b0100, 5'b00000, 5'b01000},
    {4'b1000, 5'b01000, 5'b10000},
    {4'b0001, 5'b00000, 5'b10010},
    {4'b0000, 5'b11111, 5'b00000},
    {4'b1111, 5'b00000, 5'b11110},
    {4'b0000, 5'b01010, 5'b10100},
    {4'b0000, 5'b00000, 5'b10100}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cycles(2);
    check("R2 during reset", rd_data_o, 32'h3);
    rst_ni = 1'b1;
    cycles(3);
    check("R2 R6 after reset", rd_data_o, 32'h3);

    // vector walk: one-cycle pulse and write together, then settle
    for (int v = 0; v < 10; v++) begin
      src_i     = VEC[v][13:10];
      wr_en_i   = (VEC[v][9:5] != 5'b0);
      wr_data_i = {27'h7ffffff, VEC[v][9:5]};
      cycles(1);
      src_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
      cycles(4);
      check($sformatf("R1 R4 R5 R6 R8 R9 vec%0d", v), rd_data_o, {27'b0, VEC[v][4:0]});
    end

    // R8 exact latency: pulse sampled at edge 1, visible after edge 3
    wr_en_i = 1'b1; wr_data_i = 32'h1f;
    cycles(1);
    wr_en_i = 1'b0; wr_data_i = '0;
    src_i = 4'b0010;
    cycles(1);
    src_i = '0;
    cycles(1);
    check("R8 not yet after two edges", rd_data_o, 32'h0);
    cycles(1);
    check("R8 set after third edge", rd_data_o, 32'h4);

    // R3: brown-out held across power-on release
    rst_ni = 1'b0;
    src_i  = 4'b0100;
    cycles(2);
    check("R2 reload defaults", rd_data_o, 32'h3);
    rst_ni = 1'b1;
    cycles(4);
    check("R3 held source recorded", rd_data_o, 32'hb);

    // R7: clear while cause still active
    wr_en_i = 1'b1; wr_data_i = 32'h8;
    cycles(1);
    wr_en_i = 1'b0; wr_data_i = '0;
    check("R7 cause beats clear", rd_data_o, 32'hb);

    src_i = '0;
    cycles(4);
    wr_en_i = 1'b1; wr_data_i = 32'h8;
    cycles(1);
    wr_en_i = 1'b0; wr_data_i = '0;
    check("R4 clear after source drops", rd_data_o, 32'h3);

    // R9: watchdog event leaves power-on and pin bits intact
    src_i = 4'b0010;
    cycles(1);
    src_i = '0;
    cycles(4);
    check("R9 no clear by other cause", rd_data_o, 32'h7);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule